// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

A register-mapped bank of up to 32 general-purpose pins. Software controls each pin's output latch, its drive direction and its rising and falling edge detection through a small word-wide register port. The port writes on a strobe and reads combinationally. The output latch has no plain write path. A write-one-to-set register raises latch bits and a write-one-to-clear register lowers them, so two agents can change different pins without a read-modify-write sequence.

Pad inputs pass through a two-flop synchronizer. Both the level readback and the edge detectors use the synchronized value. An enabled edge latches a sticky status bit. The OR of all status bits drives a single interrupt line, which stays high until software has cleared every set bit.

A pin-count parameter trims a partially populated bank. A per-pin polarity mask swaps the meaning of the direction bit.

Top module: `pin_bank_edge`

## Requirements
- R1: Register offsets on `regAddr` are: 0 level (read-only), 1 direction, 2 set (write-only, reads 0), 3 clear (write-only, reads 0), 4 rising enable, 5 falling enable, 6 edge status. Offset 7 reads 0 and ignores writes. Reads are combinational in the same cycle. Writes take effect at the clock edge that samples `regWrEn`.
- R2: Writing a word to the set register drives each latch bit whose data bit is 1 high. Writing to the clear register drives those latch bits low. Bits written as 0 keep their latch value. `pinOut` shows the latch on the cycle after the write.
- R3: `pinOutEn[i]` equals direction bit i XOR `DIR_INVERT[i]`. A normal pin drives when its direction bit is 1. An inverted pin drives when its direction bit is 0. The direction register reads back as written.
- R4: The level register returns the pad value through a two-flop synchronizer. A pad change made between clock edges is still unseen after one edge and is visible after the second edge. This holds for input and output pins alike.
- R5: Rising and falling enables are independent per pin, and both may be set at once. When the synchronized value of a pin changes in an enabled direction, its status bit is set after the third clock edge following the pad change, and not after the second.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an enabled edge arrives in the same cycle as the clear, the bit stays set.
- R7: `irqOut` is high exactly when any status bit is set. It stays high until every set bit has been cleared.
- R8: A pin configured as an output still detects edges on its own pad value.
- R9: Bits at or above `PIN_COUNT` read as 0 in every register, ignore writes, and hold `pinOut` and `pinOutEn` at 0.
- R10: After reset, all output latches, both enable registers and all status bits are 0. The direction register reads `DIR_INVERT`, so every pin is an input, and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | BANK_W | Write data |
| regRdData | output | BANK_W | Combinational read data for `regAddr` |
| pinIn | input | BANK_W | Pad values (asynchronous) |
| pinOut | output | BANK_W | Output latch |
| pinOutEn | output | BANK_W | Per-pin output drive enable |
| irqOut | output | 1 | Combined edge interrupt |

## Verification
The bound checker tests the following on every cycle:
- set and clear writes change exactly the addressed latch bits, and a cycle with neither write leaves `pinOut` unchanged;
- the drive enables follow a direction write through the polarity mask;
- unpopulated bits stay at zero on every output;
- `irqOut` never drops without a status write.

The directed scenarios cover the rest, which depends on a modelled pad:
- synchronizer latency for level readback and edge capture;
- independent rising and falling enables;
- write-one-to-clear semantics, including an edge that lands in the same cycle as its clear;
- edge capture on a pin the bank itself drives.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

  localparam int OFS_LEVEL = 0;
  localparam int OFS_DIR   = 1;
  localparam int OFS_SET   = 2;
  localparam int OFS_CLR   = 3;
  localparam int OFS_RISE  = 4;
  localparam int OFS_FALL  = 5;
  localparam int OFS_STAT  = 6;

  typedef enum logic [2:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_SET   = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_RISE  = 3'd4,
    SEL_FALL  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_NONE  = 3'd7
  } rdSelT;

  typedef struct packed {
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrRise;
    logic wrFall;
    logic wrStat;
  } ctrlStrobesT;

endpackage

// File: rtl/pbe_ctrl.sv
module pbe_ctrl
  import pbe_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobesT       strobes,
  output rdSelT             rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = SEL_NONE;
    if (regAddr == ADDR_W'(OFS_LEVEL)) begin
      rdSel = SEL_LEVEL;
    end else if (regAddr == ADDR_W'(OFS_DIR)) begin
      rdSel         = SEL_DIR;
      strobes.wrDir = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_SET)) begin
      rdSel         = SEL_SET;
      strobes.wrSet = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_CLR)) begin
      rdSel         = SEL_CLR;
      strobes.wrClr = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_RISE)) begin
      rdSel          = SEL_RISE;
      strobes.wrRise = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_FALL)) begin
      rdSel          = SEL_FALL;
      strobes.wrFall = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_STAT)) begin
      rdSel          = SEL_STAT;
      strobes.wrStat = regWrEn;
    end
  end

endmodule

// File: rtl/pin_edge_cell.sv
module pin_edge_cell (
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  input  logic riseEn,
  input  logic fallEn,
  output logic levelSync,
  output logic edgeHit
);

  logic stage1;
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1    <= 1'b0;
      levelSync <= 1'b0;
      prevLvl   <= 1'b0;
    end else begin
      stage1    <= padIn;
      levelSync <= stage1;
      prevLvl   <= levelSync;
    end
  end

  assign edgeHit = (riseEn & levelSync & ~prevLvl) |
                   (fallEn & ~levelSync & prevLvl);

endmodule

// File: rtl/pbe_datapath.sv
module pbe_datapath
  import pbe_pkg::*;
#(
  parameter int                BANK_W     = 32,
  parameter int                PIN_COUNT  = 32,
  parameter logic [BANK_W-1:0] DIR_INVERT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  rdSelT             rdSel,
  input  logic [BANK_W-1:0] wrData,
  input  logic [BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0] rdData,
  output logic [BANK_W-1:0] pinOut,
  output logic [BANK_W-1:0] pinOutEn,
  output logic              irqOut
);

  localparam logic [BANK_W-1:0] PRES_MASK =
    (PIN_COUNT >= BANK_W) ? {BANK_W{1'b1}} : ((BANK_W'(1) << PIN_COUNT) - BANK_W'(1));
  localparam logic [BANK_W-1:0] DIR_RESET = DIR_INVERT & PRES_MASK;

  logic [BANK_W-1:0] outLatch;
  logic [BANK_W-1:0] dirReg;
  logic [BANK_W-1:0] riseEnReg;
  logic [BANK_W-1:0] fallEnReg;
  logic [BANK_W-1:0] statReg;
  logic [BANK_W-1:0] levelVec;
  logic [BANK_W-1:0] hitVec;
  logic [BANK_W-1:0] wrMasked;

  assign wrMasked = wrData & PRES_MASK;

  for (genvar i = 0; i < BANK_W; i++) begin : g_pin
    if (i < PIN_COUNT) begin : g_live
      pin_edge_cell u_cell (
        .clk       (clk),
        .rstN      (rstN),
        .padIn     (pinIn[i]),
        .riseEn    (riseEnReg[i]),
        .fallEn    (fallEnReg[i]),
        .levelSync (levelVec[i]),
        .edgeHit   (hitVec[i])
      );
    end else begin : g_absent
      assign levelVec[i] = 1'b0;
      assign hitVec[i]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch  <= '0;
      dirReg    <= DIR_RESET;
      riseEnReg <= '0;
      fallEnReg <= '0;
      statReg   <= '0;
    end else begin
      if (strobes.wrSet)  outLatch  <= outLatch | wrMasked;
      if (strobes.wrClr)  outLatch  <= outLatch & ~wrMasked;
      if (strobes.wrDir)  dirReg    <= wrMasked;
      if (strobes.wrRise) riseEnReg <= wrMasked;
      if (strobes.wrFall) fallEnReg <= wrMasked;
      statReg <= ((statReg & ~(strobes.wrStat ? wrMasked : '0)) | hitVec) & PRES_MASK;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_LEVEL: rdData = levelVec;
      SEL_DIR:   rdData = dirReg;
      SEL_RISE:  rdData = riseEnReg;
      SEL_FALL:  rdData = fallEnReg;
      SEL_STAT:  rdData = statReg;
      default:   rdData = '0;
    endcase
  end

  assign pinOut   = outLatch;
  assign pinOutEn = (dirReg ^ DIR_INVERT) & PRES_MASK;
  assign irqOut   = |statReg;

endmodule

// File: rtl/pin_bank_edge.sv
module pin_bank_edge
  import pbe_pkg::*;
#(
  parameter int                BANK_W     = 32,
  parameter int                PIN_COUNT  = 32,
  parameter int                ADDR_W     = 3,
  parameter logic [BANK_W-1:0] DIR_INVERT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BANK_W-1:0] regWrData,
  output logic [BANK_W-1:0] regRdData,
  input  logic [BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0] pinOut,
  output logic [BANK_W-1:0] pinOutEn,
  output logic              irqOut
);

  ctrlStrobesT strobes;
  rdSelT       rdSel;

  pbe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  pbe_datapath #(
    .BANK_W     (BANK_W),
    .PIN_COUNT  (PIN_COUNT),
    .DIR_INVERT (DIR_INVERT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .pinIn    (pinIn),
    .rdData   (regRdData),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/pin_bank_edge_chk.sv
module pin_bank_edge_chk
  import pbe_pkg::*;
#(
  parameter int                BANK_W     = 32,
  parameter int                PIN_COUNT  = 32,
  parameter int                ADDR_W     = 3,
  parameter logic [BANK_W-1:0] DIR_INVERT = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [BANK_W-1:0] regWrData,
  input logic [BANK_W-1:0] regRdData,
  input logic [BANK_W-1:0] pinIn,
  input logic [BANK_W-1:0] pinOut,
  input logic [BANK_W-1:0] pinOutEn,
  input logic              irqOut
);

  localparam logic [BANK_W-1:0] PRES_MASK =
    (PIN_COUNT >= BANK_W) ? {BANK_W{1'b1}} : ((BANK_W'(1) << PIN_COUNT) - BANK_W'(1));

  logic wrSetNow;
  logic wrClrNow;
  logic wrDirNow;
  logic wrStatNow;

  assign wrSetNow  = regWrEn && (regAddr == ADDR_W'(OFS_SET));
  assign wrClrNow  = regWrEn && (regAddr == ADDR_W'(OFS_CLR));
  assign wrDirNow  = regWrEn && (regAddr == ADDR_W'(OFS_DIR));
  assign wrStatNow = regWrEn && (regAddr == ADDR_W'(OFS_STAT));

  // R2: set write raises exactly the addressed bits, others unchanged
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrSetNow |=> (pinOut == ($past(pinOut) | ($past(regWrData) & PRES_MASK))));

  // R2: clear write lowers exactly the addressed bits
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrClrNow |=> (pinOut == ($past(pinOut) & ~($past(regWrData) & PRES_MASK))));

  // R2: no set/clear write leaves the latch alone
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSetNow || wrClrNow) |=> $stable(pinOut));

  // R3: drive enables follow a direction write through the polarity mask
  p_dir_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrDirNow |=> (pinOutEn == (($past(regWrData) ^ DIR_INVERT) & PRES_MASK)));

  // R7: interrupt only drops after a status write
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !wrStatNow) |=> irqOut);

  // R9: unpopulated bits stay zero on every output
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut & ~PRES_MASK) == '0) && ((pinOutEn & ~PRES_MASK) == '0) &&
    ((regRdData & ~PRES_MASK) == '0));

endmodule

bind pin_bank_edge pin_bank_edge_chk #(
  .BANK_W     (BANK_W),
  .PIN_COUNT  (PIN_COUNT),
  .ADDR_W     (ADDR_W),
  .DIR_INVERT (DIR_INVERT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .pinIn     (pinIn),
  .pinOut    (pinOut),
  .pinOutEn  (pinOutEn),
  .irqOut    (irqOut)
);

// File: tb/tb_pin_bank_edge.sv
`timescale 1ns/1ps
module tb_pin_bank_edge;

  localparam int          BW   = 32;
  localparam int          NPIN = 24;
  localparam int          AW   = 3;
  localparam logic [31:0] INV  = 32'h0000_00F0;
  localparam logic [31:0] PRES = 32'h00FF_FFFF;

  localparam logic [2:0] A_LEVEL = 3'd0;
  localparam logic [2:0] A_DIR   = 3'd1;
  localparam logic [2:0] A_SET   = 3'd2;
  localparam logic [2:0] A_CLR   = 3'd3;
  localparam logic [2:0] A_RISE  = 3'd4;
  localparam logic [2:0] A_FALL  = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_NONE  = 3'd7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [BW-1:0] regWrData = '0;
  logic [BW-1:0] regRdData;
  logic [BW-1:0] pinIn;
  logic [BW-1:0] pinOut;
  logic [BW-1:0] pinOutEn;
  logic          irqOut;
  logic [BW-1:0] extDrive = '0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign pinIn = (pinOutEn & pinOut) | (~pinOutEn & extDrive);

  pin_bank_edge #(
    .BANK_W(BW), .PIN_COUNT(NPIN), .ADDR_W(AW), .DIR_INVERT(INV)
  ) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10", "pinOut after reset", pinOut, 32'h0);
    check("R10", "pinOutEn after reset", pinOutEn, 32'h0);
    check("R10", "irq after reset", {31'h0, irqOut}, 32'h0);
    regRead(A_DIR, v);  check("R10", "dir reset value", v, INV);
    regRead(A_RISE, v); check("R10", "rise enable reset", v, 32'h0);
    regRead(A_FALL, v); check("R10", "fall enable reset", v, 32'h0);
    regRead(A_STAT, v); check("R10", "status reset", v, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    regWrite(A_SET, 32'hFFFF_FFFF);
    check("R2", "set all", pinOut, PRES);
    regWrite(A_CLR, 32'h0000_000F);
    check("R2", "clear low nibble", pinOut, PRES & ~32'hF);
    regWrite(A_SET, 32'h0);
    check("R2", "set with zeros", pinOut, PRES & ~32'hF);
    regWrite(A_CLR, 32'h0);
    check("R2", "clear with zeros", pinOut, PRES & ~32'hF);
    regRead(A_SET, v); check("R1", "set reads 0", v, 32'h0);
    regRead(A_CLR, v); check("R1", "clear reads 0", v, 32'h0);
    regWrite(A_CLR, 32'hFFFF_FFFF);
    regWrite(A_SET, 32'h0000_0005);
    check("R2", "set after full clear", pinOut, 32'h5);
  endtask

  task automatic t_dir_level();
    logic [31:0] v;
    regWrite(A_DIR, 32'h0000_00FF);
    check("R3", "drive enables", pinOutEn, 32'h0000_000F);
    regRead(A_DIR, v); check("R3", "dir readback", v, 32'h0000_00FF);
    extDrive = 32'hFFAB_CD0A;
    waitCycles(2);
    regRead(A_LEVEL, v);
    check("R4", "level mixes outputs and inputs", v, 32'h00AB_CD05);
    regWrite(A_DIR, INV);
    check("R3", "all inputs via polarity", pinOutEn, 32'h0);
  endtask

  task automatic t_level_timing();
    logic [31:0] v;
    extDrive = 32'h0;
    waitCycles(3);
    extDrive = 32'h0012_3456;
    waitCycles(1);
    regRead(A_LEVEL, v); check("R4", "level after one edge", v, 32'h0);
    waitCycles(1);
    regRead(A_LEVEL, v); check("R4", "level after two edges", v, 32'h0012_3456);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    extDrive = 32'h0;
    waitCycles(3);
    regWrite(A_RISE, 32'h5);
    regWrite(A_FALL, 32'h6);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    extDrive = 32'h7;
    waitCycles(2);
    regRead(A_STAT, v); check("R5", "no status after two edges", v, 32'h0);
    waitCycles(1);
    regRead(A_STAT, v); check("R5", "rise-enabled bits", v, 32'h5);
    check("R7", "irq raised", {31'h0, irqOut}, 32'h1);
    extDrive = 32'h0;
    waitCycles(3);
    regRead(A_STAT, v); check("R5", "fall adds bit1, both-enabled kept", v, 32'h7);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    regWrite(A_STAT, 32'h0);
    regRead(A_STAT, v); check("R6", "write 0 no effect", v, 32'h7);
    regWrite(A_STAT, 32'h1);
    regRead(A_STAT, v); check("R6", "clear bit0", v, 32'h6);
    check("R7", "irq held with bits left", {31'h0, irqOut}, 32'h1);
    regWrite(A_STAT, 32'h2);
    check("R7", "irq held on last bit", {31'h0, irqOut}, 32'h1);
    // edge on bit2 lands in the same cycle as its clear
    extDrive = 32'h4;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    regWrite(A_STAT, 32'h4);
    regRead(A_STAT, v); check("R6", "edge beats clear", v, 32'h4);
    regWrite(A_STAT, 32'h4);
    regRead(A_STAT, v); check("R6", "final clear", v, 32'h0);
    check("R7", "irq drops when all clear", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic t_out_edge();
    logic [31:0] v;
    regWrite(A_RISE, 32'h8);
    regWrite(A_FALL, 32'h0);
    regWrite(A_DIR, INV | 32'h8);
    check("R3", "bit3 drives", pinOutEn, 32'h8);
    waitCycles(3);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regWrite(A_SET, 32'h8);
    waitCycles(2);
    regRead(A_STAT, v); check("R8", "output edge not yet", v, 32'h0);
    waitCycles(1);
    regRead(A_STAT, v); check("R8", "output pin edge seen", v, 32'h8);
    regWrite(A_STAT, 32'h8);
    regWrite(A_RISE, 32'h0);
    regWrite(A_DIR, INV);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    regWrite(A_RISE, 32'hFFFF_FFFF);
    regRead(A_RISE, v); check("R9", "rise upper bits", v, PRES);
    regWrite(A_RISE, 32'h0);
    regWrite(A_DIR, 32'hFFFF_FFFF);
    regRead(A_DIR, v); check("R9", "dir upper bits", v, PRES);
    check("R9", "enables upper bits", pinOutEn, PRES & ~INV);
    regWrite(A_NONE, 32'h0);
    regRead(A_DIR, v); check("R1", "offset 7 write ignored", v, PRES);
    regRead(A_NONE, v); check("R1", "offset 7 reads 0", v, 32'h0);
    regWrite(A_DIR, INV);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_dir_level();
    t_level_timing();
    t_edges();
    t_w1c();
    t_out_edge();
    t_unused();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule